// File: doc/BRIEF.md
# Serial Flag-Offset Programming Port

This block holds the two programmable flag thresholds of a FIFO, the almost-empty offset and the almost-full offset. Its outputs feed the flag comparators directly. Both thresholds are reached through one serial chain that moves one bit per rising edge of the serial clock. The chain can be loaded with new thresholds or clocked out to read back the thresholds currently in force. The chain starts at bit 0 of the almost-empty offset and finishes at the top bit of the almost-full offset.

Each offset is as wide as log2 of the FIFO's word depth in the current configuration. That depth depends on the port width and the transfer rate. A double-rate port halves the depth, which removes one bit from each offset. A configuration with narrow data on both ports doubles the depth, which adds one bit to each offset. The chain is always two offsets long. New thresholds reach the flag logic only when the whole chain has been shifted in. The programming sequence does not depend on the FIFO's output mode.

Top module: `ofs_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both offsets equal the default value `DEF_OFS` (127), `ser_dout` is 0 and both chain positions are at bit 0.
- R2: The offset width is W = `BASE_LOG2` + `cfg_narrow` - `cfg_ddr`, which is 14 to 16 bits by default. The chain is 2*W bits long.
- R3: Chain position k < W carries almost-empty bit k. Position W+j carries almost-full bit j. Loading takes `ser_din` in increasing position order.
- R4: `ae_offset` and `af_offset` change only on the edge that takes chain position 2*W-1. Both take their new values on that edge. A partial load leaves them unchanged.
- R5: A load step happens on an edge where `ser_en`=1, `wr_en`=0 and `rd_en`=0. When `wr_en` or `rd_en` is high, no bit is taken and no readback bit is produced. When `ser_en` and `ser_rd_en` are both high, the cycle is a load step.
- R6: A readback step happens on an edge where `ser_rd_en`=1, `ser_en`=0, `wr_en`=0 and `rd_en`=0. On that edge `ser_dout` takes the applied chain bit at the readback position, in the same order as R3. The position wraps to 0 after 2*W-1. At all other times `ser_dout` holds its value.
- R7: Completing a load sets the readback position to 0.
- R8: When `cfg_narrow` or `cfg_ddr` differs from the configuration in force, the next edge performs no step. That edge adopts the new configuration, sets both positions to 0, discards any partial load, and clears any offset bits at or above the new W.
- R9: Offset bits at or above W always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; rising edges move chain bits |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | Both data ports in the narrow-width configuration (depth doubled) |
| cfg_ddr | input | 1 | Double-rate configuration (depth halved) |
| ser_en | input | 1 | Serial load enable |
| ser_rd_en | input | 1 | Serial readback enable |
| wr_en | input | 1 | Normal FIFO write enable; blocks serial steps |
| rd_en | input | 1 | Normal FIFO read enable; blocks serial steps |
| ser_din | input | 1 | Serial load data |
| ser_dout | output | 1 | Registered serial readback data |
| ae_offset | output | BASE_LOG2+1 | Applied almost-empty offset |
| af_offset | output | BASE_LOG2+1 | Applied almost-full offset |

## Verification
A load counter that slips by one shows up at the offset outputs as soon as the chain completes. The new thresholds appear shifted, or they appear one edge early or one edge late, so the mismatch is visible on the very edge that should apply them. A readback position that is out of step appears on `ser_dout` at the next readback step. This is seen most clearly right after a completed load, where the bench expects bit 0 of the almost-empty offset. Stale wide bits after a change to a narrower configuration are visible on the offset outputs in the cycle after the change.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_READ = 2'd2
  } ser_op_e;

  function automatic int unsigned ofs_width(int unsigned base, logic narrow, logic ddr);
    return base + int'(narrow) - int'(ddr);
  endfunction
endpackage

// File: rtl/ofs_cfg.sv
module ofs_cfg #(
  parameter int BASE_LOG2 = 15,
  parameter int MAXW      = BASE_LOG2 + 1,
  parameter int WW        = $clog2(MAXW + 1),
  parameter int LW        = $clog2(2 * MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_narrow,
  input  logic            cfg_ddr,
  output logic [WW-1:0]   width,
  output logic [LW-1:0]   chain_len,
  output logic [MAXW-1:0] mask,
  output logic [MAXW-1:0] mask_new,
  output logic            cfg_chg
);
  logic narrow_q, ddr_q;
  logic [WW-1:0] width_new;

  always_ff @(posedge clk) begin
    if (rst || cfg_chg) begin
      narrow_q <= cfg_narrow;
      ddr_q    <= cfg_ddr;
    end
  end

  assign cfg_chg   = !rst && ({cfg_narrow, cfg_ddr} != {narrow_q, ddr_q});
  assign width     = WW'(ofs_pkg::ofs_width(BASE_LOG2, narrow_q, ddr_q));
  assign width_new = WW'(ofs_pkg::ofs_width(BASE_LOG2, cfg_narrow, cfg_ddr));
  assign chain_len = LW'(width) << 1;

  for (genvar i = 0; i < MAXW; i++) begin : g_mask
    assign mask[i]     = (WW'(i) < width);
    assign mask_new[i] = (WW'(i) < width_new);
  end
endmodule

// File: rtl/ofs_load.sv
module ofs_load #(
  parameter int MAXW    = 16,
  parameter int WW      = 5,
  parameter int LW      = 6,
  parameter int DEF_OFS = 127
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            clr,
  input  logic            din,
  input  logic [WW-1:0]   width,
  input  logic [LW-1:0]   chain_len,
  input  logic [MAXW-1:0] mask,
  input  logic [MAXW-1:0] mask_new,
  output logic [MAXW-1:0] ae_q,
  output logic [MAXW-1:0] af_q,
  output logic [LW-1:0]   cnt,
  output logic            commit
);
  logic [MAXW-1:0] stage_ae, stage_af, ae_n, af_n;

  assign commit = step && (cnt == chain_len - LW'(1));

  for (genvar i = 0; i < MAXW; i++) begin : g_bit
    logic hit_ae, hit_af;
    assign hit_ae  = step && (cnt == LW'(i)) && (LW'(i) < LW'(width));
    assign hit_af  = step && (cnt == LW'(width) + LW'(i));
    assign ae_n[i] = hit_ae ? din : stage_ae[i];
    assign af_n[i] = hit_af ? din : stage_af[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      stage_ae <= '0;
      stage_af <= '0;
      ae_q     <= MAXW'(DEF_OFS);
      af_q     <= MAXW'(DEF_OFS);
    end else if (clr) begin
      cnt      <= '0;
      stage_ae <= '0;
      stage_af <= '0;
      ae_q     <= ae_q & mask_new;
      af_q     <= af_q & mask_new;
    end else if (commit) begin
      cnt      <= '0;
      stage_ae <= '0;
      stage_af <= '0;
      ae_q     <= ae_n & mask;
      af_q     <= af_n & mask;
    end else if (step) begin
      cnt      <= cnt + LW'(1);
      stage_ae <= ae_n;
      stage_af <= af_n;
    end
  end
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
  parameter int MAXW = 16,
  parameter int WW   = 5,
  parameter int LW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            clr,
  input  logic            restart,
  input  logic [WW-1:0]   width,
  input  logic [LW-1:0]   chain_len,
  input  logic [MAXW-1:0] ae,
  input  logic [MAXW-1:0] af,
  output logic            dout,
  output logic [LW-1:0]   cnt
);
  logic [MAXW-1:0] pick_ae, pick_af;
  logic            cur_bit;

  for (genvar i = 0; i < MAXW; i++) begin : g_pick
    assign pick_ae[i] = ae[i] && (cnt == LW'(i)) && (LW'(i) < LW'(width));
    assign pick_af[i] = af[i] && (cnt == LW'(width) + LW'(i));
  end

  assign cur_bit = |pick_ae || |pick_af;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dout <= 1'b0;
    end else if (clr || restart) begin
      cnt  <= '0;
    end else if (step) begin
      dout <= cur_bit;
      cnt  <= (cnt == chain_len - LW'(1)) ? '0 : cnt + LW'(1);
    end
  end
endmodule

// File: rtl/ofs_port.sv
module ofs_port #(
  parameter int BASE_LOG2 = 15,
  parameter int DEF_OFS   = 127,
  parameter int MAXW      = BASE_LOG2 + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_narrow,
  input  logic            cfg_ddr,
  input  logic            ser_en,
  input  logic            ser_rd_en,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            ser_din,
  output logic            ser_dout,
  output logic [MAXW-1:0] ae_offset,
  output logic [MAXW-1:0] af_offset
);
  import ofs_pkg::*;

  localparam int WW = $clog2(MAXW + 1);
  localparam int LW = $clog2(2 * MAXW + 1);

  logic [WW-1:0]   width;
  logic [LW-1:0]   chain_len, ld_cnt, rb_cnt;
  logic [MAXW-1:0] mask, mask_new;
  logic            cfg_chg, commit;
  ser_op_e         op;

  always_comb begin
    op = OP_IDLE;
    if (!cfg_chg && !wr_en && !rd_en) begin
      if (ser_en)         op = OP_LOAD;
      else if (ser_rd_en) op = OP_READ;
    end
  end

  ofs_cfg #(.BASE_LOG2(BASE_LOG2), .MAXW(MAXW), .WW(WW), .LW(LW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow), .cfg_ddr(cfg_ddr),
    .width(width), .chain_len(chain_len), .mask(mask), .mask_new(mask_new),
    .cfg_chg(cfg_chg)
  );

  ofs_load #(.MAXW(MAXW), .WW(WW), .LW(LW), .DEF_OFS(DEF_OFS)) u_load (
    .clk(clk), .rst(rst), .step(op == OP_LOAD), .clr(cfg_chg), .din(ser_din),
    .width(width), .chain_len(chain_len), .mask(mask), .mask_new(mask_new),
    .ae_q(ae_offset), .af_q(af_offset), .cnt(ld_cnt), .commit(commit)
  );

  ofs_readback #(.MAXW(MAXW), .WW(WW), .LW(LW)) u_rb (
    .clk(clk), .rst(rst), .step(op == OP_READ), .clr(cfg_chg), .restart(commit),
    .width(width), .chain_len(chain_len), .ae(ae_offset), .af(af_offset),
    .dout(ser_dout), .cnt(rb_cnt)
  );
endmodule

// File: rtl/ofs_port_chk.sv
module ofs_port_chk #(
  parameter int MAXW    = 16,
  parameter int LW      = 6,
  parameter int DEF_OFS = 127
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            rd_en,
  input logic            ser_dout,
  input logic [MAXW-1:0] ae_offset,
  input logic [MAXW-1:0] af_offset,
  input logic [MAXW-1:0] mask,
  input logic [LW-1:0]   chain_len,
  input logic [LW-1:0]   ld_cnt,
  input logic [LW-1:0]   rb_cnt,
  input logic            cfg_chg,
  input logic            commit
);
  p_reset_defaults_r1: assert property (@(posedge clk)
    $fell(rst) |-> (ae_offset == MAXW'(DEF_OFS)) && (af_offset == MAXW'(DEF_OFS)) && !ser_dout);

  p_cnt_in_chain_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_cnt < chain_len) && (rb_cnt < chain_len));

  p_apply_only_on_commit_r4: assert property (@(posedge clk) disable iff (rst)
    (!commit && !cfg_chg) |=> $stable(ae_offset) && $stable(af_offset));

  p_blocked_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && !cfg_chg) |=> $stable(ld_cnt) && $stable(rb_cnt) && $stable(ser_dout));

  p_commit_restarts_rb_r7: assert property (@(posedge clk) disable iff (rst)
    commit |=> (rb_cnt == '0));

  p_cfg_clears_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (ld_cnt == '0) && (rb_cnt == '0));

  p_upper_bits_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ((ae_offset | af_offset) & ~mask) == '0);
endmodule

bind ofs_port ofs_port_chk #(.MAXW(MAXW), .LW(LW), .DEF_OFS(DEF_OFS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ser_dout(ser_dout),
  .ae_offset(ae_offset), .af_offset(af_offset), .mask(mask),
  .chain_len(chain_len), .ld_cnt(ld_cnt), .rb_cnt(rb_cnt),
  .cfg_chg(cfg_chg), .commit(commit)
);

// File: tb/ofs_port_tb.sv
module ofs_port_tb;
  localparam int BASE = 15;
  localparam int MAXW = BASE + 1;
  localparam int DEF  = 127;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cfg_narrow = 1'b0, cfg_ddr = 1'b0;
  logic ser_en = 1'b0, ser_rd_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ser_din = 1'b0;
  logic ser_dout;
  logic [MAXW-1:0] ae_offset, af_offset;

  int n_chk = 0, n_fail = 0;
  int m_ae = DEF, m_af = DEF, m_rb = 0;
  bit m_dout = 0, m_n = 0, m_d = 0;
  bit q[$];

  ofs_port #(.BASE_LOG2(BASE), .DEF_OFS(DEF)) u_dut (
    .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow), .cfg_ddr(cfg_ddr),
    .ser_en(ser_en), .ser_rd_en(ser_rd_en), .wr_en(wr_en), .rd_en(rd_en),
    .ser_din(ser_din), .ser_dout(ser_dout), .ae_offset(ae_offset), .af_offset(af_offset)
  );

  function automatic int mw();
    return BASE + int'(m_n) - int'(m_d);
  endfunction

  function automatic bit chain_bit(int ae, int af, int k);
    return (k < mw()) ? bit'((ae >> k) & 1) : bit'((af >> (k - mw())) & 1);
  endfunction

  task automatic chk(string tag, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_ae = DEF; m_af = DEF; m_rb = 0; m_dout = 0; q.delete();
      m_n = cfg_narrow; m_d = cfg_ddr;
    end else if (cfg_narrow != m_n || cfg_ddr != m_d) begin
      m_n = cfg_narrow; m_d = cfg_ddr;
      q.delete(); m_rb = 0;
      m_ae = m_ae & ((1 << mw()) - 1);
      m_af = m_af & ((1 << mw()) - 1);
    end else if (!wr_en && !rd_en && ser_en) begin
      q.push_back(ser_din);
      if (q.size() == 2 * mw()) begin
        m_ae = 0; m_af = 0;
        for (int i = 0; i < mw(); i++) begin
          m_ae |= int'(q[i]) << i;
          m_af |= int'(q[mw() + i]) << i;
        end
        q.delete(); m_rb = 0;
      end
    end else if (!wr_en && !rd_en && ser_rd_en) begin
      m_dout = chain_bit(m_ae, m_af, m_rb);
      m_rb = (m_rb + 1) % (2 * mw());
    end
  endtask

  task automatic tick(string tag, bit r, bit se, bit sr, bit we, bit re, bit din);
    rst = r; ser_en = se; ser_rd_en = sr; wr_en = we; rd_en = re; ser_din = din;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " ae"}, ae_offset == MAXW'(m_ae), int'(ae_offset), m_ae);
    chk({tag, " af"}, af_offset == MAXW'(m_af), int'(af_offset), m_af);
    chk({tag, " dout"}, ser_dout == m_dout, int'(ser_dout), int'(m_dout));
  endtask

  task automatic shift_range(string tag, int ae, int af, int from, int upto);
    for (int k = from; k < upto; k++) tick(tag, 0, 1, 0, 0, 0, chain_bit(ae, af, k));
  endtask

  task automatic read_n(string tag, int n);
    for (int k = 0; k < n; k++) tick(tag, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int k = 0; k < 3; k++) tick("R1 reset", 1, 1, 0, 0, 0, 1);
    tick("R1 after reset", 0, 0, 0, 0, 0, 0);
    chk("R1 direct", ae_offset == MAXW'(DEF) && af_offset == MAXW'(DEF), int'(ae_offset), DEF);

    // R3: full load in the base configuration (W=15, 30 bits)
    shift_range("R3 load", 16'h1234, 16'h0ABC, 0, 30);
    chk("R3 direct ae", ae_offset == 16'h1234, int'(ae_offset), 16'h1234);
    chk("R3 direct af", af_offset == 16'h0ABC, int'(af_offset), 16'h0ABC);

    // R4: partial load leaves applied offsets alone
    shift_range("R4 partial", 16'h7FFF, 16'h0001, 0, 10);
    chk("R4 direct", ae_offset == 16'h1234, int'(ae_offset), 16'h1234);

    // R5: normal enables block serial steps
    for (int k = 0; k < 3; k++) tick("R5 wr_en block", 0, 1, 0, 1, 0, 0);
    for (int k = 0; k < 2; k++) tick("R5 rd_en block", 0, 1, 1, 0, 1, 0);
    shift_range("R5 resume", 16'h7FFF, 16'h0001, 10, 29);
    tick("R5 load wins", 0, 1, 1, 0, 0, chain_bit(16'h7FFF, 16'h0001, 29));
    chk("R4 applied", af_offset == 16'h0001, int'(af_offset), 1);

    // R6: readback with wrap
    read_n("R6 readback", 35);
    tick("R5 read blocked", 0, 0, 1, 1, 0, 0);

    // R7: completing a load restarts readback
    read_n("R7 pre", 7);
    shift_range("R7 load", 16'h2AAA, 16'h5555, 0, 30);
    read_n("R7 restart", 4);

    // R8 + R2: config change mid-load, then narrow (W=16)
    shift_range("R8 partial", 16'h0F0F, 16'h0F0F, 0, 9);
    cfg_narrow = 1'b1;
    tick("R8 cfg change", 0, 1, 0, 0, 0, 1);
    shift_range("R2 narrow", 16'hFFFF, 16'h8001, 0, 32);
    chk("R2 narrow direct", af_offset == 16'h8001, int'(af_offset), 16'h8001);
    read_n("R2 narrow readback", 33);

    // R9 + R2: double rate (W=14) masks wide bits
    cfg_narrow = 1'b0; cfg_ddr = 1'b1;
    tick("R9 cfg shrink", 0, 0, 0, 0, 0, 0);
    chk("R9 shrink direct", ae_offset == 16'h3FFF, int'(ae_offset), 16'h3FFF);
    shift_range("R2 ddr", 16'hFFFF, 16'hFFFF, 0, 28);
    chk("R9 direct", af_offset == 16'h3FFF, int'(af_offset), 16'h3FFF);
    read_n("R6 ddr readback", 29);

    // R2: narrow and double rate together (W=15)
    cfg_narrow = 1'b1;
    tick("R8 cfg both", 0, 0, 1, 0, 0, 0);
    shift_range("R2 both", 16'h4321, 16'h1357, 0, 30);
    read_n("R6 both readback", 30);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule